// File: doc/BRIEF.md
# Cascadable Nibble-Loaded LCD Column Driver Core

This block is the digital part of a dot-matrix LCD column (segment) driver with 80 outputs. Display data comes in four bits per shift strobe. A line of 80 dots therefore takes 20 strobes. An active-low enable chain lets several of these drivers share one data bus. Each device takes its 20 nibbles, then pulls its chain output low to hand the bus to the next device. A direction input chooses which chain pin acts as the input and which as the output. The same input reverses the order in which nibbles are placed across the outputs.

When the whole row has been sent, a load strobe copies the shift content into an output latch. The same strobe re-arms every device in the chain for the next line. For each output, a 2-bit code selects one of four bias levels. The code depends on the latched dot, an alternating frame signal and an active-low blanking input. The analog stages outside this block turn the code into a voltage.

All logic runs on one clock. `shift_stb` and `load_stb` are single-cycle qualifiers that stand for the active edges of the shift and load clocks.

Top module: `seg_col_driver`

## Requirements
- R1: A synchronous active-low reset has these results. The shift content, the output latch and the nibble count are cleared. Both chain outputs read 1, so every output code is 1 when `frame` is 0 and `blank_n` is 1.
- R2: A shift strobe is accepted only when all of these hold: the active chain input is 0, fewer than 20 nibbles have been accepted since the last load or reset, and `load_stb` is 0. Any other strobe leaves the shift content unchanged.
- R3: With `dir` = 0, `ena_right_n` is the chain input. Each accepted nibble enters at outputs 77..80, with `nib[0]` at output 77, and the earlier content moves down by four outputs. After 20 nibbles, the first nibble sits on outputs 1..4 (`nib[0]` on output 1) and the last on outputs 77..80.
- R4: With `dir` = 1, `ena_left_n` is the chain input. Each accepted nibble enters at outputs 4..1, with `nib[0]` at output 4, and the earlier content moves up by four outputs. After 20 nibbles, the first nibble sits on outputs 80..77 (`nib[0]` on output 80).
- R5: The chain output on the active side is 1 until the 20th nibble of a line has been accepted. It reads 0 from the cycle after that strobe. The chain output on the input side always reads 1. With `dir` = 0 the active-side output is `done_left_n`; with `dir` = 1 it is `done_right_n`.
- R6: `load_stb` copies all 80 shift bits into the latch. It also clears the nibble count, so the chain output returns to 1 in the next cycle.
- R7: Output n is driven on bits [2n-1:2n-2] of `lvl`. When `blank_n` is 1, the code is chosen as follows:
  - `frame` 0, dot 0: code 1
  - `frame` 0, dot 1: code 0
  - `frame` 1, dot 0: code 2
  - `frame` 1, dot 1: code 3
- R8: While `blank_n` is 0, every output code is 0, whatever the latch and `frame` hold.
- R9: The chain input of the side that is not selected by `dir` has no effect on whether strobes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | Shift direction and chain pin role select |
| ena_right_n | input | 1 | Right chain input, active low (used when dir=0) |
| ena_left_n | input | 1 | Left chain input, active low (used when dir=1) |
| done_right_n | output | 1 | Right chain output (active when dir=1) |
| done_left_n | output | 1 | Left chain output (active when dir=0) |
| shift_stb | input | 1 | Nibble shift qualifier |
| nib | input | 4 | Display data nibble |
| load_stb | input | 1 | Line latch qualifier, re-arms the chain |
| frame | input | 1 | Alternating frame signal |
| blank_n | input | 1 | Display off when low |
| lvl | output | 160 | Two-bit bias level code per output |

## Verification
Suppose the nibble counter drifts by one. The chain output then drops one strobe early or late, which shows up at the next full line. A nibble that was wrongly accepted or dropped shifts the whole latched image by four outputs. That error appears on `lvl` right after the next load. A wrong direction mux scrambles the output order in a way that bench-computed images catch at once. Errors in the level encoding and in blanking are seen in the same cycle that `frame` or `blank_n` changes.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

   typedef enum logic [1:0] {
      LV_V1  = 2'd0,
      LV_V3  = 2'd1,
      LV_V4  = 2'd2,
      LV_VEE = 2'd3
   } lvl_e;

   function automatic lvl_e pick_level(input logic dot, input logic frame, input logic blank_n);
      lvl_e r;
      if (!blank_n)    r = LV_V1;
      else if (!frame) r = dot ? LV_V1  : LV_V3;
      else             r = dot ? LV_VEE : LV_V4;
      return r;
   endfunction

endpackage

// File: rtl/seg_enable_ctl.sv
module seg_enable_ctl #(
   parameter int STAGES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir,
   input  logic ena_right_n,
   input  logic ena_left_n,
   input  logic shift_stb,
   input  logic load_stb,
   output logic accept,
   output logic done_right_n,
   output logic done_left_n
);
   localparam int CNT_W = $clog2(STAGES + 1);

   logic [CNT_W-1:0] cnt;
   logic             chain_in_n;
   logic             full;

   assign chain_in_n = dir ? ena_left_n : ena_right_n;
   assign full       = (cnt == CNT_W'(STAGES));
   assign accept     = shift_stb && !load_stb && !chain_in_n && !full;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (load_stb) cnt <= '0;
      else if (accept)   cnt <= cnt + CNT_W'(1);
   end

   assign done_left_n  = dir ? 1'b1  : !full;
   assign done_right_n = dir ? !full : 1'b1;

   // R2: the count never passes a full line
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(STAGES));

   // R5: the last accepted nibble fills the line
   a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cnt == CNT_W'(STAGES - 1)) |=> (cnt == CNT_W'(STAGES)));

   // R5: the input-side chain output stays high
   a_r5_idle_side: assert property (@(posedge clk) disable iff (!rst_n)
      (dir ? done_left_n : done_right_n));

   // R6: load re-arms
   a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (cnt == '0));

endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
   parameter int NUM_OUT = 80,
   parameter int NIB_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dir,
   input  logic               accept,
   input  logic [NIB_W-1:0]   nib,
   output logic [NUM_OUT-1:0] line
);
   logic [NIB_W-1:0] nib_rev;

   for (genvar k = 0; k < NIB_W; k++) begin : g_rev
      assign nib_rev[k] = nib[NIB_W-1-k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         line <= '0;
      else if (accept) begin
         if (dir) line <= {line[NUM_OUT-NIB_W-1:0], nib_rev};
         else     line <= {nib, line[NUM_OUT-1:NIB_W]};
      end
   end

   // R2: without an accepted strobe the content holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(line));

endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
   import seg_drv_pkg::*;
#(
   parameter int NUM_OUT = 80
) (
   input  logic [NUM_OUT-1:0]   dots,
   input  logic                 frame,
   input  logic                 blank_n,
   output logic [2*NUM_OUT-1:0] codes
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign codes[2*i +: 2] = pick_level(dots[i], frame, blank_n);
   end
endmodule

// File: rtl/seg_col_driver.sv
module seg_col_driver #(
   parameter int NUM_OUT = 80,
   parameter int NIB_W   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dir,
   input  logic                 ena_right_n,
   input  logic                 ena_left_n,
   output logic                 done_right_n,
   output logic                 done_left_n,
   input  logic                 shift_stb,
   input  logic [NIB_W-1:0]     nib,
   input  logic                 load_stb,
   input  logic                 frame,
   input  logic                 blank_n,
   output logic [2*NUM_OUT-1:0] lvl
);
   localparam int STAGES = NUM_OUT / NIB_W;

   if (NIB_W < 1 || NUM_OUT % NIB_W != 0) begin : g_bad_width
      $error("NUM_OUT must be a multiple of NIB_W");
   end
   if (STAGES < 2) begin : g_bad_depth
      $error("at least two shift stages are needed");
   end

   logic               accept;
   logic [NUM_OUT-1:0] line;
   logic [NUM_OUT-1:0] latch_q;

   seg_enable_ctl #(.STAGES(STAGES)) u_ctl (
      .clk(clk), .rst_n(rst_n), .dir(dir),
      .ena_right_n(ena_right_n), .ena_left_n(ena_left_n),
      .shift_stb(shift_stb), .load_stb(load_stb),
      .accept(accept),
      .done_right_n(done_right_n), .done_left_n(done_left_n)
   );

   seg_shift_chain #(.NUM_OUT(NUM_OUT), .NIB_W(NIB_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .dir(dir), .accept(accept),
      .nib(nib), .line(line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        latch_q <= '0;
      else if (load_stb) latch_q <= line;
   end

   seg_level_enc #(.NUM_OUT(NUM_OUT)) u_enc (
      .dots(latch_q), .frame(frame), .blank_n(blank_n), .codes(lvl)
   );

   // R6: the latch takes the shift content on load
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (latch_q == $past(line)));

   // R6: without load the latch holds
   a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb |=> $stable(latch_q));

   // R8: blanking forces every code to V1
   a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> (lvl == '0));

endmodule

// File: tb/seg_col_driver_test.sv
module seg_col_driver_test;
   localparam int N  = 80;
   localparam int NB = 4;
   localparam int ST = N / NB;

   logic clk = 1'b0;
   logic rst_n, dir, ena_right_n, ena_left_n, shift_stb, load_stb, frame, blank_n;
   logic [NB-1:0]  nib;
   logic           done_right_n, done_left_n;
   logic [2*N-1:0] lvl;

   int tests = 0, fails = 0;
   logic [N-1:0] m_sr, m_latch;
   int m_cnt;

   always #2 clk = ~clk;

   seg_col_driver #(.NUM_OUT(N), .NIB_W(NB)) uut (
      .clk(clk), .rst_n(rst_n), .dir(dir),
      .ena_right_n(ena_right_n), .ena_left_n(ena_left_n),
      .done_right_n(done_right_n), .done_left_n(done_left_n),
      .shift_stb(shift_stb), .nib(nib), .load_stb(load_stb),
      .frame(frame), .blank_n(blank_n), .lvl(lvl)
   );

   function automatic logic [1:0] exp_code(input logic d, input logic f, input logic b);
      if (!b) return 2'd0;
      if (!f) return d ? 2'd0 : 2'd1;
      return d ? 2'd3 : 2'd2;
   endfunction

   task automatic check1(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_lvl(input string req);
      int bad = -1;
      tests++;
      for (int i = 0; i < N; i++)
         if (bad < 0 && lvl[2*i +: 2] !== exp_code(m_latch[i], frame, blank_n)) bad = i;
      if (bad >= 0) begin
         fails++;
         $display("FAIL %s output %0d actual=%0d expected=%0d", req, bad + 1,
                  lvl[2*bad +: 2], exp_code(m_latch[bad], frame, blank_n));
      end
   endtask

   task automatic do_shift(input logic [NB-1:0] v, input logic with_load);
      logic cin;
      @(negedge clk);
      shift_stb = 1'b1; nib = v; load_stb = with_load;
      cin = dir ? ena_left_n : ena_right_n;
      if (with_load) begin
         m_latch = m_sr; m_cnt = 0;
      end else if (!cin && m_cnt < ST) begin
         m_cnt++;
         for (int k = 0; k < NB; k++) begin
            if (!dir) begin
               m_sr = m_sr >> 1; m_sr[N-1] = 1'b0;
            end else begin
               m_sr = m_sr << 1;
            end
         end
         for (int k = 0; k < NB; k++) begin
            if (!dir) m_sr[N-NB+k] = v[k];
            else      m_sr[NB-1-k] = v[k];
         end
      end
      @(negedge clk);
      shift_stb = 1'b0; load_stb = 1'b0;
   endtask

   task automatic do_load();
      @(negedge clk);
      load_stb = 1'b1;
      m_latch = m_sr; m_cnt = 0;
      @(negedge clk);
      load_stb = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; dir = 1'b0; ena_right_n = 1'b1; ena_left_n = 1'b1;
      shift_stb = 1'b0; load_stb = 1'b0; nib = '0; frame = 1'b0; blank_n = 1'b1;
      m_sr = '0; m_latch = '0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check1("R1 done_left_n", done_left_n, 1);
      check1("R1 done_right_n", done_right_n, 1);
      check_lvl("R1 reset codes");

      // R2: chain input high, strobes ignored
      for (int i = 0; i < 5; i++) do_shift(NB'($urandom), 1'b0);
      // R9: wrong-side chain input low, still ignored
      ena_left_n = 1'b0;
      for (int i = 0; i < 5; i++) do_shift(NB'($urandom), 1'b0);
      ena_left_n = 1'b1;
      do_load();
      check_lvl("R2/R9 ignored strobes");

      for (int line = 0; line < 8; line++) begin
         dir = (line < 2) ? line[0] : 1'($urandom);
         ena_right_n = dir;
         ena_left_n  = !dir;
         for (int i = 0; i < ST; i++) begin
            if (i == ST - 1)
               check1("R5 before last nibble", dir ? done_right_n : done_left_n, 1);
            do_shift((line == 0 && i < 2) ? NB'(i + 1) : NB'($urandom), 1'b0);
         end
         check1("R5 handoff low", dir ? done_right_n : done_left_n, 0);
         check1("R5 input side high", dir ? done_left_n : done_right_n, 1);
         do_shift(NB'($urandom), 1'b0);
         do_shift(NB'($urandom), 1'b0);
         do_load();
         check_lvl(dir ? "R4 line image" : "R3 line image");
         check1("R6 rearm", dir ? done_right_n : done_left_n, 1);
         frame = 1'b1;  #1 check_lvl("R7 frame high");
         frame = 1'b0;  #1 check_lvl("R7 frame low");
         blank_n = 1'b0; #1 check_lvl("R8 blank");
         frame = 1'b1;  #1 check_lvl("R8 blank frame high");
         blank_n = 1'b1; frame = 1'($urandom);
      end

      // R3 directed: first nibble 1 -> output 1 set, output 5 low (nibble 2 = 0010)
      begin
         logic [N-1:0] snap = m_latch;
         dir = 1'b0; ena_right_n = 1'b0; ena_left_n = 1'b1;
         for (int i = 0; i < ST; i++) do_shift(NB'(i == 0 ? 1 : (i == 1 ? 2 : 0)), 1'b0);
         do_load();
         frame = 1'b0; blank_n = 1'b1;
         #1 check1("R3 output1 dot", lvl[1:0], 0);
         check1("R3 output6 dot", lvl[11:10], 0);
         check1("R3 output5 dark", lvl[9:8], 1);
         if (snap == '1) check1("R3 snap", 0, 0);
      end

      // R4 directed: first nibble 1 -> output 80 set
      dir = 1'b1; ena_right_n = 1'b1; ena_left_n = 1'b0;
      for (int i = 0; i < ST; i++) do_shift(NB'(i == 0 ? 1 : 0), 1'b0);
      do_load();
      #1 check1("R4 output80 dot", lvl[2*N-1 -: 2], 0);
      check1("R4 output79 dark", lvl[2*N-3 -: 2], 1);

      // R6 priority: shift with load is dropped
      do_shift(4'hF, 1'b1);
      do_load();
      check_lvl("R6 load beats shift");

      // R1: reset clears latch
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      m_sr = '0; m_latch = '0; m_cnt = 0;
      #1 check_lvl("R1 reset after data");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule